// File: doc/BRIEF.md
# Partially Decoded Nibble I/O Ports

This block holds the I/O port logic that sits on the 4-bit data bus of a small processor. It has one input port and two 4-bit output registers. The input port places the levels of four pushbutton pins onto the bus whenever an input instruction executes. Each pin has a pull-up, so a pressed button reads as 0. The returned value is given as a data nibble plus a drive-enable, and the surrounding bus logic merges it.

The output registers do not use a full port-number decoder. Both share one active-low load strobe. Each register also has a second active-low enable, taken directly from one bit of the port number. Output register 1 feeds the four data lines a character LCD uses in 4-bit mode. Output register 0 feeds the LCD register-select and enable lines, a debug LED and a speaker bit, which software toggles to make square-wave tones.

Because the decode is partial, several port numbers reach the same register. A port number whose two low bits are both 0 writes both registers in the same cycle. The asynchronous active-low reset is released through a two-stage synchronizer.

Top module: `nib_io_ports`

## Requirements
- R1: While reset is asserted, and until the first load after reset is released, every output pin of both output registers (lcd_data, lcd_rs, lcd_e, led, spk) is 0. Load requests made during reset are ignored.
- R2: At a rising clock edge where load_out_n is 0 and port_num bit 0 is 0, output register 0 captures wr_data.
- R3: At a rising clock edge where load_out_n is 0 and port_num bit 1 is 0, output register 1 captures wr_data.
- R4: When load_out_n is 0 and port_num bits 1 and 0 are both 0, both registers capture the same wr_data at the same edge.
- R5: A register whose port_num select bit is 1, or any register while load_out_n is 1, keeps its value whatever wr_data holds.
- R6: port_num bits above bit 1 have no effect on which register loads.
- R7: Output register 0 bits map to pins as follows: bit 0 drives spk, bit 1 drives led, bit 2 drives lcd_e, and bit 3 drives lcd_rs.
- R8: Output register 1 bit i drives lcd_data bit i. These four lines are the upper LCD data lines used in 4-bit mode.
- R9: While in_rd is 1, in_drv_en is 1 and in_drv equals the btn_pin_n levels for any port_num. A pressed button (pin low) reads 0. This path is combinational, with no clock delay.
- R10: While in_rd is 0, in_drv_en is 0 and in_drv is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; output registers capture on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| load_out_n | input | 1 | Shared active-low output-load strobe |
| port_num | input | 4 | Port number of the current I/O instruction |
| wr_data | input | 4 | Nibble to be written to the selected output register(s) |
| in_rd | input | 1 | High while an input instruction executes |
| btn_pin_n | input | 4 | Pushbutton pin levels; 0 means the button is pressed |
| in_drv | output | 4 | Nibble the input port returns to the bus |
| in_drv_en | output | 1 | High when in_drv should be driven onto the bus |
| lcd_data | output | 4 | LCD data nibble, taken from output register 1 |
| lcd_rs | output | 1 | LCD register select, output register 0 bit 3 |
| lcd_e | output | 1 | LCD enable strobe, output register 0 bit 2 |
| led | output | 1 | Debug LED, output register 0 bit 1 |
| spk | output | 1 | Speaker bit, output register 0 bit 0 |

## Verification
The output path is swept over all sixteen port numbers, with the load strobe both low and high, and with a different data nibble at every step. This separates a correct partial decode from a full decode, from swapped select bits, and from decode that wrongly depends on the upper port bits. Writing to port numbers 0, 4, 8 and 12 shows that both registers load at once. Because the written value differs from the value each register already holds, a register that loads when it should not is always caught.

The input port is swept over all sixteen button patterns and several port numbers, with the read strobe both high and low. This shows that the returned value is not inverted, that the port answers every port number, and that the bus drive is parked when the port is not read.

// File: rtl/nib_io_pkg.sv
package nib_io_pkg;
  // data bus nibble width
  localparam int unsigned NIB_W = 4;
  // number of partially decoded output registers
  localparam int unsigned N_OUT = 2;
  // index of the register holding control/misc pins
  localparam int unsigned CTL_REG = 0;
  // index of the register holding the LCD data nibble
  localparam int unsigned LCD_REG = 1;
  // bit placement inside the control register
  localparam int unsigned SPK_BIT = 0;
  localparam int unsigned LED_BIT = 1;
  localparam int unsigned LCDE_BIT = 2;
  localparam int unsigned LCDRS_BIT = 3;

  typedef logic [NIB_W-1:0] nib_t;
endpackage

// File: rtl/nib_rst_sync.sv
module nib_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/nib_in_port.sv
module nib_in_port
  import nib_io_pkg::*;
(
  input  logic clk,
  input  logic rst_sync_n,
  input  logic rd_i,
  input  nib_t pins_n_i,
  output nib_t drv_o,
  output logic drv_en_o
);
  // pins already read 0 when pressed (pull-ups); pass levels through
  always_comb begin
    drv_en_o = rd_i;
    drv_o    = rd_i ? pins_n_i : '0;
  end

  // R10
  idle_park_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rd_i |-> (!drv_en_o && drv_o == '0));
  // R9
  rd_pass_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_i |-> (drv_en_o && drv_o == pins_n_i));
endmodule

// File: rtl/nib_out_reg.sv
module nib_out_reg
  import nib_io_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_a_n,
  input  logic en_b_n,
  input  nib_t d_i,
  output nib_t q_o
);
  logic ld;
  nib_t q_r;
  nib_t q_nxt;

  always_comb begin
    ld    = ~en_a_n & ~en_b_n;
    q_nxt = q_r;
    if (ld) q_nxt = d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_nxt;
  end

  assign q_o = q_r;

  // R1
  rst_zero_chk: assert property (@(posedge clk) !rst_n |-> q_o == '0);
  // R2 R3
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_a_n && !en_b_n) |=> q_o == $past(d_i));
  // R5
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_a_n || en_b_n) |=> $stable(q_o));
endmodule

// File: rtl/nib_io_ports.sv
module nib_io_ports
  import nib_io_pkg::*;
#(
  parameter int unsigned PORT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_out_n,
  input  logic [PORT_W-1:0] port_num,
  input  logic [NIB_W-1:0]  wr_data,
  input  logic              in_rd,
  input  logic [NIB_W-1:0]  btn_pin_n,
  output logic [NIB_W-1:0]  in_drv,
  output logic              in_drv_en,
  output logic [NIB_W-1:0]  lcd_data,
  output logic              lcd_rs,
  output logic              lcd_e,
  output logic              led,
  output logic              spk
);
  logic rst_sync_n;
  nib_t out_q [N_OUT];

  nib_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  nib_in_port u_in (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .rd_i       (in_rd),
    .pins_n_i   (btn_pin_n),
    .drv_o      (in_drv),
    .drv_en_o   (in_drv_en)
  );

  // each register's second enable is one raw port-number bit
  for (genvar g = 0; g < N_OUT; g++) begin : g_out
    nib_out_reg u_reg (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .en_a_n (load_out_n),
      .en_b_n (port_num[g]),
      .d_i    (wr_data),
      .q_o    (out_q[g])
    );
  end

  always_comb begin
    lcd_data = out_q[LCD_REG];
    spk      = out_q[CTL_REG][SPK_BIT];
    led      = out_q[CTL_REG][LED_BIT];
    lcd_e    = out_q[CTL_REG][LCDE_BIT];
    lcd_rs   = out_q[CTL_REG][LCDRS_BIT];
  end

  // R4
  dual_load_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!load_out_n && port_num[1:0] == 2'b00) |=>
      (lcd_data == $past(wr_data) &&
       {lcd_rs, lcd_e, led, spk} == $past(wr_data)));
  // R7
  ctl_map_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!load_out_n && !port_num[0]) |=>
      (spk == $past(wr_data[0]) && lcd_rs == $past(wr_data[3])));
  // R8
  lcd_map_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!load_out_n && !port_num[1]) |=> lcd_data == $past(wr_data));
endmodule

// File: tb/tb_nib_io_ports.sv
module tb_nib_io_ports;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       load_out_n;
  logic [3:0] port_num;
  logic [3:0] wr_data;
  logic       in_rd;
  logic [3:0] btn_pin_n;
  logic [3:0] in_drv;
  logic       in_drv_en;
  logic [3:0] lcd_data;
  logic       lcd_rs, lcd_e, led, spk;

  int total = 0;
  int bad = 0;
  logic [3:0] m0, m1;

  always #2 clk = ~clk;

  nib_io_ports dut (
    .clk(clk), .rst_n(rst_n), .load_out_n(load_out_n), .port_num(port_num),
    .wr_data(wr_data), .in_rd(in_rd), .btn_pin_n(btn_pin_n), .in_drv(in_drv),
    .in_drv_en(in_drv_en), .lcd_data(lcd_data), .lcd_rs(lcd_rs), .lcd_e(lcd_e),
    .led(led), .spk(spk)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] ctl_pins();
    // R7 mapping: bit3 rs, bit2 e, bit1 led, bit0 spk
    return {lcd_rs, lcd_e, led, spk};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; load_out_n = 1'b0; port_num = 4'h0; wr_data = 4'hF;
    in_rd = 1'b0; btn_pin_n = 4'hF;
    repeat (3) @(negedge clk);
    // R1: loads during reset ignored
    chk("R1 rst ctl", {4'h0, ctl_pins()}, 8'h00);
    chk("R1 rst lcd", {4'h0, lcd_data}, 8'h00);
    load_out_n = 1'b1;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 post ctl", {4'h0, ctl_pins()}, 8'h00);
    chk("R1 post lcd", {4'h0, lcd_data}, 8'h00);
    m0 = 4'h0; m1 = 4'h0;

    // R2 R3 R4 R5 R6 R7 R8: sweep port numbers, strobe states
    for (int pass = 0; pass < 3; pass++) begin
      for (int p = 0; p < 16; p++) begin
        for (int s = 0; s < 2; s++) begin
          logic [3:0] d;
          d = (p[3:0] * 4'd5 + pass[3:0] * 4'd7 + s[3:0] * 4'd3 + 4'd1);
          // force a value differing from both registers
          while (d == m0 || d == m1) d = d + 4'd1;
          load_out_n = s[0];
          port_num   = p[3:0];
          wr_data    = d;
          if (!s[0] && !p[0]) m0 = d;
          if (!s[0] && !p[1]) m1 = d;
          @(negedge clk);
          if (p[1:0] == 2'b00 && !s[0]) begin
            chk("R4 both ctl", {4'h0, ctl_pins()}, {4'h0, d});
            chk("R4 both lcd", {4'h0, lcd_data}, {4'h0, d});
          end else if (s[0]) begin
            chk("R5 strobe high ctl", {4'h0, ctl_pins()}, {4'h0, m0});
            chk("R5 strobe high lcd", {4'h0, lcd_data}, {4'h0, m1});
          end else begin
            chk("R2 R6 R7 ctl", {4'h0, ctl_pins()}, {4'h0, m0});
            chk("R3 R6 R8 lcd", {4'h0, lcd_data}, {4'h0, m1});
          end
        end
      end
    end
    load_out_n = 1'b1;

    // R9 R10: input port
    for (int p = 0; p < 16; p += 5) begin
      for (int b = 0; b < 16; b++) begin
        port_num = p[3:0]; btn_pin_n = b[3:0];
        in_rd = 1'b1;
        #1;
        chk("R9 read", {3'b0, in_drv_en, in_drv}, {4'h1, b[3:0]});
        in_rd = 1'b0;
        #1;
        chk("R10 park", {3'b0, in_drv_en, in_drv}, 8'h00);
        @(negedge clk);
      end
    end
    // R5: input activity leaves output registers alone
    chk("R5 after reads", {lcd_data, ctl_pins()}, {m1, m0});

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule